// File: doc/BRIEF.md
# Transmit Multiframe Clock and Link-Start Sequencer

This block keeps the transmit-side multiframe phase of a deterministic-latency serial link and decides which character type each lane sends in every link clock cycle. A counter counts link clock cycles modulo the multiframe length. A reference pulse arriving on `sysref_in` realigns that counter to a value that software has programmed, not to zero. This moves the transmit multiframe boundary by a chosen number of cycles, so the phase error against the far-end receiver can be trimmed.

The second half of the block is the link-start sequencer. It watches the active-low synchronisation request `sync_n_in`. While that request is held low, the block sends comma characters. After it detects the release, it waits for the next multiframe boundary and then plays out a fixed alignment preamble of four multiframes. Once the preamble ends, it hands the lanes to user data. If the request is asserted again, the block returns to commas. The character encoding, the serialisers and the receiver are outside this block.

Top module: `mfc_link_start`

## Requirements
- R1: After reset, `lmfc_count` is 0, and it then advances by one every cycle, wrapping from MF_LEN-1 (7 by default) back to 0, whenever no realignment takes place.
- R2: `lmfc_strobe` is 1 in exactly those cycles in which `lmfc_count` is 0.
- R3: Suppose `sysref_in` is driven high before rising edge P0 after having been low, and the block is armed. Then `lmfc_count` equals the programmed offset in the cycle after edge P3. The next strobe therefore follows (MF_LEN - offset) mod MF_LEN cycles later, and an offset of 0 gives a strobe in the realignment cycle itself.
- R4: One rising level of `sysref_in` gives at most one realignment, however long the level is held. After a realignment the block is disarmed: later pulses leave the count on its free-running course until `rearm` has been high for one cycle. The block is armed out of reset.
- R5: The block sends comma characters (`char_type` = 0) and reports `link_state` = 0 while `sync_n_in` is low, and it keeps doing so after the release until the preamble starts.
- R6: The release is detected in the cycle after the second rising edge following the rise of `sync_n_in`. The preamble begins in the first later cycle in which `lmfc_count` is 0. A boundary that falls in the detection cycle itself is not used.
- R7: The preamble lasts 4 multiframes of MF_LEN cycles each, with `link_state` = 1. Each multiframe starts with a start marker (code 1) and ends with an end marker (code 3). Position 1 of the second multiframe carries a configuration marker (code 2). All other positions carry filler (code 4), and `fill_byte` counts 0,1,2,… over the filler positions. `fill_byte` is 0 whenever the character is not filler.
- R8: Directly after the preamble, the block sends user data (code 5) and reports `link_state` = 2.
- R9: If `sync_n_in` goes low during the preamble or during user data, the block is back to commas with `link_state` = 0 in the cycle after the third rising edge. It stays there until a new release.
- R10: A write through `ofs_wr`/`ofs_val` updates the offset only while `link_state` is 0. A write during preamble or user data is dropped, and the next realignment loads the earlier value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sysref_in | input | 1 | Asynchronous phase reference pulse |
| sync_n_in | input | 1 | Asynchronous synchronisation request, active low |
| rearm | input | 1 | One-cycle pulse that allows the next reference pulse to realign |
| ofs_wr | input | 1 | Write strobe for the realignment offset |
| ofs_val | input | $clog2(MF_LEN) | Offset value, below MF_LEN |
| lmfc_count | output | $clog2(MF_LEN) | Current multiframe phase |
| lmfc_strobe | output | 1 | Multiframe boundary, high when the phase is 0 |
| link_state | output | 2 | 0 comma, 1 preamble, 2 user data |
| char_type | output | 3 | 0 comma, 1 start, 2 config, 3 end, 4 filler, 5 user data |
| fill_byte | output | 8 | Filler value on filler positions, else 0 |

## Verification
The phase counter is visible on the ports, so a wrong count or a missed wrap shows in the same cycle on `lmfc_count` and on the strobe. A wrongly latched offset stays hidden until the next realignment, and the bench therefore forces that realignment and compares the count against the expected offset. A sequencer that takes the wrong state shows up within one cycle on `char_type` and `link_state`. A preamble that starts on the wrong boundary shifts the whole marker pattern, so the start marker appears where the count is not 0.

// File: rtl/mfc_pkg.sv
// Shared types for the multiframe clock and link-start sequencer.
// Assumes: the character codes are consumed as listed by a downstream encoder.
package mfc_pkg;
    typedef enum logic [2:0] {
        CH_K = 3'd0,
        CH_R = 3'd1,
        CH_Q = 3'd2,
        CH_A = 3'd3,
        CH_F = 3'd4,
        CH_D = 3'd5
    } char_e;

    typedef enum logic [1:0] {
        LS_CGS  = 2'd0,
        LS_ILAS = 2'd1,
        LS_DATA = 2'd2
    } lstate_e;

    typedef enum logic [1:0] {
        SQ_CGS  = 2'd0,
        SQ_PEND = 2'd1,
        SQ_ILAS = 2'd2,
        SQ_DATA = 2'd3
    } seq_e;
endpackage

// File: rtl/mfc_sync.sv
// Two-flop synchroniser for a vector of independent asynchronous bits.
// Assumes: each bit is a slow level or a pulse wider than one clock cycle.
module mfc_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages per bit, both cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/mfc_lmfc_ctr.sv
// Free-running multiframe phase counter with offset realignment.
// What it does: detects a rising edge of the synchronised reference, waits
// SR_DLY cycles in total, then loads the held offset. It also gives a one-shot arm.
// Assumes: the offset is below MF_LEN, and SR_DLY >= 2.
module mfc_lmfc_ctr #(
    parameter int MF_LEN = 8,
    parameter int SR_DLY = 2,
    localparam int CW = $clog2(MF_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sysref_s,
    input  logic          rearm,
    input  logic          ofs_wr_en,
    input  logic [CW-1:0] ofs_val,
    output logic [CW-1:0] cnt,
    output logic          strobe,
    output logic          wrap_next,
    output logic          realign,
    output logic [CW-1:0] ofs_q
);
    localparam logic [CW-1:0] LAST = CW'(MF_LEN - 1);

    logic                sr_d;
    logic                armed;
    logic                edge_ok;
    logic [SR_DLY-1:1]   dly;
    logic [CW-1:0]       cnt_next;

    assign edge_ok = sysref_s & ~sr_d & armed;
    assign realign = dly[SR_DLY-1];

    // Edge history, one-shot arm, and the first delay stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_d   <= 1'b0;
            armed  <= 1'b1;
            dly[1] <= 1'b0;
        end else begin
            sr_d   <= sysref_s;
            dly[1] <= edge_ok;
            if (edge_ok)    armed <= 1'b0;
            else if (rearm) armed <= 1'b1;
        end
    end

    // Further delay stages when the realignment latency exceeds two.
    for (genvar i = 2; i < SR_DLY; i++) begin : g_dly
        always_ff @(posedge clk) begin
            if (!rst_n) dly[i] <= 1'b0;
            else        dly[i] <= dly[i-1];
        end
    end

    // Next phase: the offset on realignment, otherwise a modulo increment.
    always_comb begin
        if (realign)         cnt_next = ofs_q;
        else if (cnt == LAST) cnt_next = '0;
        else                 cnt_next = cnt + CW'(1);
    end

    assign wrap_next = (cnt_next == '0);
    assign strobe    = (cnt == '0);

    // Phase register and offset register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            ofs_q <= '0;
        end else begin
            cnt <= cnt_next;
            if (ofs_wr_en) ofs_q <= ofs_val;
        end
    end
endmodule

// File: rtl/mfc_ilas_seq.sv
// Link-start sequencer: comma -> wait for boundary -> alignment preamble -> data.
// Assumes: sync_s is already synchronised, and wrap_next is 1 when the phase
// counter reads 0 in the next cycle. MF_LEN >= 3, ILAS_MFS >= 2.
module mfc_ilas_seq #(
    parameter int MF_LEN   = 8,
    parameter int ILAS_MFS = 4,
    parameter int FILL_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_s,
    input  logic              wrap_next,
    output logic [1:0]        link_state,
    output logic [2:0]        char_type,
    output logic [FILL_W-1:0] fill_byte
);
    import mfc_pkg::*;

    localparam int PW = $clog2(MF_LEN);
    localparam int MW = $clog2(ILAS_MFS);
    localparam logic [PW-1:0] LASTP = PW'(MF_LEN - 1);
    localparam logic [MW-1:0] LASTM = MW'(ILAS_MFS - 1);

    seq_e              sq, sq_n;
    char_e             ch;
    logic              sync_d;
    logic              rel_edge;
    logic [PW-1:0]     pos;
    logic [MW-1:0]     mf;
    logic [FILL_W-1:0] fcnt;

    assign rel_edge = sync_s & ~sync_d;

    // Next state: a request drop always wins, else walk the start-up order.
    always_comb begin
        sq_n = sq;
        if (!sync_s) begin
            sq_n = SQ_CGS;
        end else begin
            case (sq)
                SQ_CGS:  if (rel_edge)  sq_n = wrap_next ? SQ_ILAS : SQ_PEND;
                SQ_PEND: if (wrap_next) sq_n = SQ_ILAS;
                SQ_ILAS: if (pos == LASTP && mf == LASTM) sq_n = SQ_DATA;
                default: sq_n = sq;
            endcase
        end
    end

    // Character choice from the state and the position inside the preamble.
    always_comb begin
        case (sq)
            SQ_ILAS: begin
                if (pos == '0)                           ch = CH_R;
                else if (pos == LASTP)                   ch = CH_A;
                else if (mf == MW'(1) && pos == PW'(1))  ch = CH_Q;
                else                                     ch = CH_F;
            end
            SQ_DATA: ch = CH_D;
            default: ch = CH_K;
        endcase
    end

    // State, preamble position, multiframe index and filler counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq     <= SQ_CGS;
            sync_d <= 1'b0;
            pos    <= '0;
            mf     <= '0;
            fcnt   <= '0;
        end else begin
            sq     <= sq_n;
            sync_d <= sync_s;
            if (sq != SQ_ILAS) begin
                pos  <= '0;
                mf   <= '0;
                fcnt <= '0;
            end else begin
                pos <= (pos == LASTP) ? '0 : pos + PW'(1);
                if (pos == LASTP) mf   <= mf + MW'(1);
                if (ch == CH_F)   fcnt <= fcnt + FILL_W'(1);
            end
        end
    end

    // Reported state folds the boundary wait into the comma state.
    always_comb begin
        case (sq)
            SQ_ILAS: link_state = LS_ILAS;
            SQ_DATA: link_state = LS_DATA;
            default: link_state = LS_CGS;
        endcase
    end

    assign char_type = ch;
    assign fill_byte = (ch == CH_F) ? fcnt : '0;
endmodule

// File: rtl/mfc_link_start.sv
// Top: synchronises the reference and the request, runs the phase counter
// and the link-start sequencer, and gates offset writes to the comma state.
// Assumes: a single link clock domain; the two inputs are asynchronous.
module mfc_link_start #(
    parameter int MF_LEN   = 8,
    parameter int ILAS_MFS = 4,
    parameter int SR_DLY   = 2,
    parameter int FILL_W   = 8,
    localparam int CW = $clog2(MF_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sysref_in,
    input  logic              sync_n_in,
    input  logic              rearm,
    input  logic              ofs_wr,
    input  logic [CW-1:0]     ofs_val,
    output logic [CW-1:0]     lmfc_count,
    output logic              lmfc_strobe,
    output logic [1:0]        link_state,
    output logic [2:0]        char_type,
    output logic [FILL_W-1:0] fill_byte
);
    import mfc_pkg::*;

    logic [1:0]    sq_in;
    logic          sysref_s;
    logic          sync_s;
    logic          wrap_next;
    logic          realign;
    logic [CW-1:0] ofs_q;
    logic          ofs_wr_en;

    mfc_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sync_n_in, sysref_in}),
        .q     (sq_in)
    );

    assign sysref_s  = sq_in[0];
    assign sync_s    = sq_in[1];
    assign ofs_wr_en = ofs_wr & (link_state == LS_CGS);

    mfc_lmfc_ctr #(.MF_LEN(MF_LEN), .SR_DLY(SR_DLY)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .sysref_s  (sysref_s),
        .rearm     (rearm),
        .ofs_wr_en (ofs_wr_en),
        .ofs_val   (ofs_val),
        .cnt       (lmfc_count),
        .strobe    (lmfc_strobe),
        .wrap_next (wrap_next),
        .realign   (realign),
        .ofs_q     (ofs_q)
    );

    mfc_ilas_seq #(.MF_LEN(MF_LEN), .ILAS_MFS(ILAS_MFS), .FILL_W(FILL_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_s     (sync_s),
        .wrap_next  (wrap_next),
        .link_state (link_state),
        .char_type  (char_type),
        .fill_byte  (fill_byte)
    );
endmodule

// File: rtl/mfc_link_start_chk.sv
// Property checker for mfc_link_start, attached with bind below.
// Assumes: it observes the top's ports plus the realign, offset and synchronised request nets.
module mfc_link_start_chk #(
    parameter int MF_LEN = 8,
    parameter int FILL_W = 8,
    localparam int CW = $clog2(MF_LEN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CW-1:0]     lmfc_count,
    input logic              lmfc_strobe,
    input logic [1:0]        link_state,
    input logic [2:0]        char_type,
    input logic [FILL_W-1:0] fill_byte,
    input logic              realign,
    input logic [CW-1:0]     ofs_q,
    input logic              sync_s
);
    localparam logic [CW-1:0] LAST = CW'(MF_LEN - 1);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!realign && lmfc_count != LAST) |=> lmfc_count == $past(lmfc_count) + CW'(1)); // R1
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!realign && lmfc_count == LAST) |=> lmfc_count == '0); // R1
    AST_LOAD_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> lmfc_count == $past(ofs_q)); // R3
    AST_COMMA_IN_CGS: assert property (@(posedge clk) disable iff (!rst_n)
        link_state == 2'd0 |-> char_type == 3'd0); // R5
    AST_ILAS_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'd1 && $past(link_state) != 2'd1) |-> lmfc_strobe); // R6
    AST_FILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        char_type != 3'd4 |-> fill_byte == '0); // R7
    AST_DROP_TO_CGS: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_s |=> link_state == 2'd0); // R9
    AST_OFS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        link_state != 2'd0 |=> $stable(ofs_q)); // R10
endmodule

bind mfc_link_start mfc_link_start_chk #(.MF_LEN(MF_LEN), .FILL_W(FILL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lmfc_count  (lmfc_count),
    .lmfc_strobe (lmfc_strobe),
    .link_state  (link_state),
    .char_type   (char_type),
    .fill_byte   (fill_byte),
    .realign     (realign),
    .ofs_q       (ofs_q),
    .sync_s      (sync_s)
);

// File: tb/mfc_link_start_test.sv
// Directed bench for mfc_link_start: one task per scenario.
module mfc_link_start_test;
    localparam int CLK_PERIOD = 10;
    localparam int MFL = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sysref_in = 1'b0;
    logic       sync_n_in = 1'b0;
    logic       rearm = 1'b0;
    logic       ofs_wr = 1'b0;
    logic [2:0] ofs_val = '0;
    logic [2:0] lmfc_count;
    logic       lmfc_strobe;
    logic [1:0] link_state;
    logic [2:0] char_type;
    logic [7:0] fill_byte;

    int n_chk = 0;
    int n_fail = 0;
    int cur_ofs = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mfc_link_start uut (
        .clk(clk), .rst_n(rst_n), .sysref_in(sysref_in), .sync_n_in(sync_n_in),
        .rearm(rearm), .ofs_wr(ofs_wr), .ofs_val(ofs_val),
        .lmfc_count(lmfc_count), .lmfc_strobe(lmfc_strobe),
        .link_state(link_state), .char_type(char_type), .fill_byte(fill_byte)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Reset values, then the free-running count and strobe (R1, R2).
    task automatic t_reset();
        tick(); tick();
        chk("R1 reset count", lmfc_count, 0);
        chk("R2 reset strobe", lmfc_strobe, 1);
        chk("R5 reset state", link_state, 0);
        chk("R5 reset char", char_type, 0);
        rst_n = 1'b1;
        for (int k = 1; k <= 10; k++) begin
            tick();
            chk("R1 free count", lmfc_count, k % MFL);
            chk("R2 strobe on zero", lmfc_strobe, (k % MFL) == 0);
        end
    endtask

    // Offset write, optional rearm, and a reference pulse of given width (R3, R4).
    task automatic t_align(input int ofs, input int width, input bit do_rearm);
        if (do_rearm) begin
            rearm = 1'b1; tick(); rearm = 1'b0;
        end
        ofs_wr = 1'b1; ofs_val = 3'(ofs); tick(); ofs_wr = 1'b0;
        cur_ofs = ofs;
        sysref_in = 1'b1;
        repeat (width) tick();
        sysref_in = 1'b0;
        repeat (4 - width) tick();
        chk("R3 count loads offset", lmfc_count, ofs);
        for (int d = 0; d < 10; d++) begin
            chk("R3 strobe delay", lmfc_strobe, (d % MFL) == ((MFL - ofs) % MFL));
            chk("R4 single realign", lmfc_count, (ofs + d) % MFL);
            tick();
        end
    endtask

    // A pulse without rearm must leave the count on its course (R4).
    task automatic t_ignored();
        int c0;
        ofs_wr = 1'b1; ofs_val = 3'd2; tick(); ofs_wr = 1'b0;
        cur_ofs = 2;
        c0 = lmfc_count;
        sysref_in = 1'b1; tick(); sysref_in = 1'b0;
        tick(); tick(); tick();
        chk("R4 disarmed pulse ignored", lmfc_count, (c0 + 4) % MFL);
        tick(); tick();
        chk("R4 disarmed count runs on", lmfc_count, (c0 + 6) % MFL);
    endtask

    // Release at a chosen phase; check wait, preamble and optional drop (R5-R9).
    task automatic t_link(input int rel_cnt, input int drop_at);
        int c2, n, f, e;
        int guard = 0;
        while (lmfc_count != rel_cnt && guard < 16) begin tick(); guard++; end
        sync_n_in = 1'b1;
        tick();
        chk("R5 comma after release", char_type, 0);
        tick();
        c2 = lmfc_count;
        chk("R5 comma in detect cycle", char_type, 0);
        n = 0;
        do begin
            tick(); n++;
            if (lmfc_count != 0) begin
                chk("R5 comma while waiting", char_type, 0);
                chk("R5 state while waiting", link_state, 0);
            end
        end while (lmfc_count != 0 && n < 10);
        chk("R6 wait to boundary", n, (c2 == 0) ? MFL : (MFL - c2));
        f = 0;
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < MFL; p++) begin
                if (drop_at == m * MFL + p) begin
                    sync_n_in = 1'b0;
                    tick(); tick(); tick();
                    chk("R9 drop in preamble state", link_state, 0);
                    chk("R9 drop in preamble char", char_type, 0);
                    for (int w = 0; w < 10; w++) begin
                        tick();
                        chk("R9 stays in comma", link_state, 0);
                    end
                    return;
                end
                if (p == 0) e = 1;
                else if (p == MFL - 1) e = 3;
                else if (m == 1 && p == 1) e = 2;
                else e = 4;
                chk("R7 preamble char", char_type, e);
                chk("R7 preamble state", link_state, 1);
                chk("R7 fill value", fill_byte, (e == 4) ? f : 0);
                if (e == 4) f++;
                tick();
            end
        end
        for (int k = 0; k < 5; k++) begin
            chk("R8 data char", char_type, 5);
            chk("R8 data state", link_state, 2);
            tick();
        end
    endtask

    // Offset write outside comma state is dropped (R10).
    task automatic t_ofs_lock();
        ofs_wr = 1'b1; ofs_val = 3'd6; tick(); ofs_wr = 1'b0;
        rearm = 1'b1; tick(); rearm = 1'b0;
        sysref_in = 1'b1; tick(); sysref_in = 1'b0;
        tick(); tick(); tick();
        chk("R10 old offset kept", lmfc_count, cur_ofs);
        chk("R10 link undisturbed", link_state, 2);
    endtask

    // Request drop during user data (R9).
    task automatic t_drop_data();
        sync_n_in = 1'b0;
        tick(); tick(); tick();
        chk("R9 drop in data state", link_state, 0);
        chk("R9 drop in data char", char_type, 0);
        tick(); tick();
        chk("R9 comma held", char_type, 0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        t_reset();
        t_align(4, 1, 1'b0);
        t_align(5, 1, 1'b1);
        t_ignored();
        t_align(0, 4, 1'b1);
        t_link(5, -1);
        t_ofs_lock();
        t_drop_data();
        t_link(6, -1);
        t_drop_data();
        t_link(3, 10);
        t_link(1, -1);
        t_drop_data();
        finish_run();
    end
endmodule